// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a 32-bit up-counter for general timing work. In timer mode it advances when a programmable 32-bit prescaler expires, and the prescaler itself steps on a peripheral clock enable. In counter mode the prescaler is bypassed and the count advances on edges of one selected capture input, so the block counts external events. Four match registers compare against the count. On a match, each one can flag an interrupt, restart the count or halt it, and each drives its own external output with a set, clear, toggle or no-change action. Four capture channels synchronise their inputs and latch the count on a chosen edge.

Software reaches every setting through a small word-addressed register port. Writes take effect on the clock edge and reads are combinational. Interrupt flags are sticky and are cleared by writing ones. The interrupt output is high while any flag is set.

Top module: `match_capture_timer`

Register map (word address, field positions):
- 0 control: bit0 run, bit1 hold-in-reset, bits3:2 source (0 prescaled ticks, 1 rising, 2 falling, 3 both edges), bits5:4 counter-mode input select
- 1 count (read/write)
- 2 prescale limit
- 3 prescale count (read only)
- 4 match control, 3 bits per match i at bit 3i: interrupt, restart, halt
- 5 capture control, 3 bits per channel i at bit 3i: rising, falling, interrupt
- 6 external outputs: bits3:0 output state (writable), 2-bit action for match i at bit 4+2i (0 none, 1 low, 2 high, 3 toggle)
- 7 flags: bits3:0 match, bits7:4 capture; a 1 written to a bit clears it
- 8..11 match values; 12..15 captured values (read only)

## Requirements
- R1: In timer mode, with prescale limit P and run set, the count rises by one on every (P+1)-th cycle in which tick_en is high. The prescale count cycles from 0 to P.
- R2: The count is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R3: When an advance brings the count equal to match value i and the match's interrupt bit is set, flag bit i sets and irq goes high.
- R4: With the restart bit of match i set, the count holds the match value for one full prescaled tick and becomes 0 at the next advance.
- R5: With the halt bit of match i set, reaching the match clears the run bit (control bit0) and the count stays at the match value.
- R6: When match i is reached, ext_match[i] follows its action code: 0 unchanged, 1 low, 2 high, 3 toggled. Writing address 6 loads the output state directly.
- R7: Capture channel i latches the count on each enabled edge of cap_in[i], after a two-flop synchronizer. If its interrupt bit is set, flag bit 4+i sets. Edges that are not enabled leave the captured value unchanged.
- R8: In counter mode (source 1, 2 or 3), the count advances on rising, falling or both edges of the selected cap_in, and the prescale count stays 0.
- R9: While the hold bit (control bit1) is set, the count and the prescale count are held at 0.
- R10: With run clear, or with tick_en low in timer mode, the count does not change.
- R11: Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and irq falls when no flag remains set.
- R12: A write to address 1 loads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Peripheral clock enable feeding the prescaler |
| cap_in | input | 4 | Capture / event inputs, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| ext_match | output | 4 | External match outputs |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The assertions assume that cap_in is low when reset is released and that each event pulse lasts at least two clock cycles, so that the synchronizer sees every edge. They also assume that a software count write happens on a cycle the bench knows about, so that the step and stability properties can exclude it. The stimulus holds cap_in low through reset and separates input toggles by four cycles. Count writes go only through the register port while the bench tracks them, and the random tick_en and match patterns vary only timing, never the register protocol.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_COUNT = 4'd1;
  localparam logic [3:0] A_PLIM  = 4'd2;
  localparam logic [3:0] A_PCNT  = 4'd3;
  localparam logic [3:0] A_MCTL  = 4'd4;
  localparam logic [3:0] A_CCTL  = 4'd5;
  localparam logic [3:0] A_ECTL  = 4'd6;
  localparam logic [3:0] A_FLAG  = 4'd7;
  localparam logic [3:0] A_MBASE = 4'd8;
  localparam logic [3:0] A_CBASE = 4'd12;

  // new level of one external output after its match fires
  function automatic logic ext_next(input logic cur, input act_e a);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic         tick_en,
  input  tmr_pkg::src_e mode,
  input  logic         sel_rise,
  input  logic         sel_fall,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pc,
  output logic         adv
);
  import tmr_pkg::*;

  logic active;
  logic expire;
  logic src_hit;

  assign active = run & ~hold;
  // >= so that lowering the limit below the running count still expires
  assign expire = (pc >= limit);

  always_comb begin
    case (mode)
      SRC_TICK: src_hit = tick_en & expire;
      SRC_RISE: src_hit = sel_rise;
      SRC_FALL: src_hit = sel_fall;
      default:  src_hit = sel_rise | sel_fall;
    endcase
  end

  assign adv = active & src_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (hold || mode != SRC_TICK) begin
      pc <= '0;
    end else if (active && tick_en) begin
      pc <= expire ? '0 : pc + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_capture_bank.sv
module tmr_capture_bank #(
  parameter int W  = 32,
  parameter int NC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NC-1:0]        cap_in,
  input  logic [W-1:0]         count,
  input  logic [NC-1:0]        rise_en,
  input  logic [NC-1:0]        fall_en,
  output logic [NC-1:0]        rise,
  output logic [NC-1:0]        fall,
  output logic [NC-1:0]        cap_evt,
  output logic [NC-1:0][W-1:0] cap_val
);
  for (genvar g = 0; g < NC; g++) begin : g_ch
    // [0],[1] synchronizer, [2] previous synchronized level
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], cap_in[g]};
    end

    assign rise[g]    = sh[1] & ~sh[2];
    assign fall[g]    = ~sh[1] & sh[2];
    assign cap_evt[g] = (rise[g] & rise_en[g]) | (fall[g] & fall_en[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_val[g] <= '0;
      else if (cap_evt[g]) cap_val[g] <= count;
    end
  end
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
  parameter int W  = 32,
  parameter int NM = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [W-1:0]         count,
  input  logic [W-1:0]         nxt,
  input  logic [NM-1:0][W-1:0] match_val,
  input  logic [2*NM-1:0]      act,
  input  logic                 ext_we,
  input  logic [NM-1:0]        ext_wdata,
  output logic [NM-1:0]        at_match,
  output logic [NM-1:0]        hit,
  output logic [NM-1:0]        ext
);
  import tmr_pkg::*;

  for (genvar g = 0; g < NM; g++) begin : g_cmp
    assign at_match[g] = (count == match_val[g]);
    assign hit[g]      = adv & (nxt == match_val[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext <= '0;
    end else begin
      logic [NM-1:0] e;
      e = ext_we ? ext_wdata : ext;
      for (int i = 0; i < NM; i++) begin
        if (hit[i]) e[i] = ext_next(e[i], act_e'(act[2*i +: 2]));
      end
      ext <= e;
    end
  end
endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [NC-1:0] cap_in,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic [NM-1:0] ext_match,
  output logic          irq
);
  import tmr_pkg::*;

  localparam int SELW   = (NC > 1) ? $clog2(NC) : 1;
  localparam int FLAG_W = NM + NC;

  // control state
  logic                 run_q;
  logic                 hold_q;
  src_e                 mode_q;
  logic [SELW-1:0]      sel_q;
  logic [W-1:0]         count_q;
  logic [W-1:0]         plim_q;
  logic [3*NM-1:0]      mctl_q;
  logic [3*NC-1:0]      cctl_q;
  logic [2*NM-1:0]      eact_q;
  logic [FLAG_W-1:0]    flags_q;
  logic [NM-1:0][W-1:0] match_q;

  // internal events, named for the checker
  logic                 adv;
  logic [W-1:0]         pc_q;
  logic [W-1:0]         nxt;
  logic [NM-1:0]        at_match;
  logic [NM-1:0]        hit;
  logic [NM-1:0]        irq_en, rst_en, stop_en;
  logic [NC-1:0]        rise_en, fall_en, cap_irq_en;
  logic [NC-1:0]        rise, fall, cap_evt;
  logic [NC-1:0][W-1:0] cap_val;
  logic                 any_rst, any_stop;

  logic wr_ctrl, wr_count, wr_plim, wr_mctl, wr_cctl, wr_ectl, wr_flag;
  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign wr_count = reg_we && reg_addr == A_COUNT;
  assign wr_plim  = reg_we && reg_addr == A_PLIM;
  assign wr_mctl  = reg_we && reg_addr == A_MCTL;
  assign wr_cctl  = reg_we && reg_addr == A_CCTL;
  assign wr_ectl  = reg_we && reg_addr == A_ECTL;
  assign wr_flag  = reg_we && reg_addr == A_FLAG;

  // count value taken at the next advance
  function automatic logic [W-1:0] step_count(input logic [W-1:0] cur, input logic restart);
    return restart ? '0 : cur + 1'b1;
  endfunction

  for (genvar g = 0; g < NM; g++) begin : g_mfield
    assign irq_en[g]  = mctl_q[3*g];
    assign rst_en[g]  = mctl_q[3*g+1];
    assign stop_en[g] = mctl_q[3*g+2];
  end

  for (genvar g = 0; g < NC; g++) begin : g_cfield
    assign rise_en[g]    = cctl_q[3*g];
    assign fall_en[g]    = cctl_q[3*g+1];
    assign cap_irq_en[g] = cctl_q[3*g+2];
  end

  assign any_rst  = |(at_match & rst_en);
  assign any_stop = |(hit & stop_en);
  assign nxt      = step_count(count_q, any_rst);

  tmr_prescale #(.W(W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .hold     (hold_q),
    .tick_en  (tick_en),
    .mode     (mode_q),
    .sel_rise (rise[sel_q]),
    .sel_fall (fall[sel_q]),
    .limit    (plim_q),
    .pc       (pc_q),
    .adv      (adv)
  );

  tmr_capture_bank #(.W(W), .NC(NC)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_in  (cap_in),
    .count   (count_q),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .rise    (rise),
    .fall    (fall),
    .cap_evt (cap_evt),
    .cap_val (cap_val)
  );

  tmr_match_bank #(.W(W), .NM(NM)) u_mat (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .count     (count_q),
    .nxt       (nxt),
    .match_val (match_q),
    .act       (eact_q),
    .ext_we    (wr_ectl),
    .ext_wdata (reg_wdata[NM-1:0]),
    .at_match  (at_match),
    .hit       (hit),
    .ext       (ext_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      mode_q <= SRC_TICK;
      sel_q  <= '0;
    end else begin
      run_q <= (wr_ctrl ? reg_wdata[0] : run_q) & ~any_stop;
      if (wr_ctrl) begin
        hold_q <= reg_wdata[1];
        mode_q <= src_e'(reg_wdata[3:2]);
        sel_q  <= reg_wdata[4 +: SELW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (hold_q)   count_q <= '0;
    else if (wr_count) count_q <= reg_wdata;
    else if (adv)      count_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plim_q <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      eact_q <= '0;
    end else begin
      if (wr_plim) plim_q <= reg_wdata;
      if (wr_mctl) mctl_q <= reg_wdata[3*NM-1:0];
      if (wr_cctl) cctl_q <= reg_wdata[3*NC-1:0];
      if (wr_ectl) eact_q <= reg_wdata[NM +: 2*NM];
    end
  end

  for (genvar g = 0; g < NM; g++) begin : g_mreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       match_q[g] <= '0;
      else if (reg_we && reg_addr == A_MBASE + 4'(g))   match_q[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~(wr_flag ? reg_wdata[FLAG_W-1:0] : '0))
               | {cap_evt & cap_irq_en, hit & irq_en};
    end
  end

  assign irq = |flags_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]        = run_q;
        reg_rdata[1]        = hold_q;
        reg_rdata[3:2]      = mode_q;
        reg_rdata[4 +: SELW] = sel_q;
      end
      A_COUNT: reg_rdata = count_q;
      A_PLIM:  reg_rdata = plim_q;
      A_PCNT:  reg_rdata = pc_q;
      A_MCTL:  reg_rdata[3*NM-1:0] = mctl_q;
      A_CCTL:  reg_rdata[3*NC-1:0] = cctl_q;
      A_ECTL: begin
        reg_rdata[NM-1:0]     = ext_match;
        reg_rdata[NM +: 2*NM] = eact_q;
      end
      A_FLAG:  reg_rdata[FLAG_W-1:0] = flags_q;
      default: begin
        for (int i = 0; i < NM; i++)
          if (reg_addr == A_MBASE + 4'(i)) reg_rdata = match_q[i];
        for (int i = 0; i < NC; i++)
          if (reg_addr == A_CBASE + 4'(i)) reg_rdata = cap_val[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      count_q,
  input logic [W-1:0]      pc_q,
  input logic              run_q,
  input logic              hold_q,
  input logic              adv,
  input logic [NM-1:0]     hit,
  input logic [NM-1:0]     at_match,
  input logic [NM-1:0]     rst_en,
  input logic [NM-1:0]     stop_en,
  input logic [NM+NC-1:0]  flags_q,
  input logic [NM-1:0]     ext_match
);
  import tmr_pkg::*;

  logic wr_count, wr_flag, wr_ectl, restart;
  assign wr_count = reg_we && reg_addr == A_COUNT;
  assign wr_flag  = reg_we && reg_addr == A_FLAG;
  assign wr_ectl  = reg_we && reg_addr == A_ECTL;
  assign restart  = |(at_match & rst_en);

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (count_q == '0 && pc_q == '0));

  assert_no_adv_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !adv);

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold_q && !wr_count && !restart) |=> count_q == $past(count_q) + W'(1));

  assert_stable_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !hold_q && !wr_count) |=> $stable(count_q));

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold_q && !wr_count && restart) |=> count_q == '0);

  assert_halt_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & stop_en)) |=> !run_q);

  assert_ext_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && !wr_ectl) |=> $stable(ext_match));

  for (genvar g = 0; g < NM + NC; g++) begin : g_sticky
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[g] && !(wr_flag && reg_wdata[g])) |=> flags_q[g]);
  end
endmodule

bind match_capture_timer tmr_checker #(.W(W), .NM(NM), .NC(NC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .count_q   (count_q),
  .pc_q      (pc_q),
  .run_q     (run_q),
  .hold_q    (hold_q),
  .adv       (adv),
  .hit       (hit),
  .at_match  (at_match),
  .rst_en    (rst_en),
  .stop_en   (stop_en),
  .flags_q   (flags_q),
  .ext_match (ext_match)
);

// File: tb/sim_match_capture_timer.sv
module sim_match_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [3:0]  cap_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  ext_match;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  match_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_match(ext_match), .irq(irq)
  );

  // expected count after n enabled ticks with prescale limit p
  function automatic int ticks_to_count(int n, int p);
    return n / (p + 1);
  endfunction

  function automatic int ticks_to_pc(int n, int p);
    return n % (p + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at posedge+1, write lands on the next edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart_run(input int plim);
    wr(4'd0, 32'h2);
    wr(4'd2, plim);
    wr(4'd7, 32'hFF);
    wr(4'd0, 32'h1);
  endtask

  task automatic toggle_cap(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      cap_in[ch] = ~cap_in[ch];
      edges(4);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ones;
    void'($urandom(32'd1234));
    edges(3);
    rst_n = 1'b1;
    edges(1);

    // reset state
    rd(4'd1, v); chk("R12 reset count", v, 0);
    rd(4'd0, v); chk("R10 reset control", v, 0);
    chk("R11 reset irq", {31'd0, irq}, 0);
    chk("R6 reset ext", {28'd0, ext_match}, 0);

    // R10: idle without run
    edges(10);
    rd(4'd1, v); chk("R10 no run no count", v, 0);

    // R1: fixed prescale limit
    restart_run(3);
    edges(22);
    rd(4'd1, v); chk("R1 count P=3", v, ticks_to_count(22, 3));
    rd(4'd3, v); chk("R1 prescale P=3", v, ticks_to_pc(22, 3));

    // R1/R10: random tick_en
    for (int r = 0; r < 3; r++) begin
      int p;
      p = $urandom % 3;
      restart_run(p);
      ones = 0;
      for (int k = 0; k < 60; k++) begin
        tick_en = 1'($urandom % 2);
        if (tick_en) ones++;
        edges(1);
      end
      tick_en = 1'b1;
      rd(4'd1, v); chk("R10 gated tick count", v, ticks_to_count(ones, p));
      rd(4'd3, v); chk("R1 gated prescale", v, ticks_to_pc(ones, p));
    end

    // R9: hold forces zero
    restart_run(2);
    edges(10);
    wr(4'd0, 32'h3);
    edges(5);
    rd(4'd1, v); chk("R9 hold count", v, 0);
    rd(4'd3, v); chk("R9 hold prescale", v, 0);

    // R3/R4: restart on match, P=1
    wr(4'd8, 32'd5);
    wr(4'd4, 32'h3);
    restart_run(1);
    edges(11);
    rd(4'd1, v); chk("R4 match value held", v, 5);
    rd(4'd7, v); chk("R3 match flag", v, 32'h1);
    chk("R3 irq high", {31'd0, irq}, 1);
    edges(1);
    rd(4'd1, v); chk("R4 restart to zero", v, 0);

    // R11: write-one-to-clear
    wr(4'd7, 32'h0);
    rd(4'd7, v); chk("R11 write zero keeps", v, 32'h1);
    wr(4'd7, 32'h1);
    rd(4'd7, v); chk("R11 write one clears", v, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R3/R4 random matches
    for (int r = 0; r < 6; r++) begin
      int p, m;
      p = $urandom % 4;
      m = 1 + ($urandom % 20);
      wr(4'd8, m);
      restart_run(p);
      edges(m * (p + 1));
      rd(4'd1, v); chk("R3 random reach", v, m);
      chk("R3 random irq", {31'd0, irq}, 1);
      edges(p + 1);
      rd(4'd1, v); chk("R4 random restart", v, 0);
    end

    // R5: halt on match 1
    wr(4'd4, 32'h20);
    wr(4'd9, 32'd7);
    restart_run(0);
    edges(7);
    rd(4'd1, v); chk("R5 reach halt", v, 7);
    edges(10);
    rd(4'd1, v); chk("R5 count frozen", v, 7);
    rd(4'd0, v); chk("R5 run cleared", v & 32'h1, 0);

    // R6: output actions (m0 toggle, m1 high, m2 low, m3 none)
    wr(4'd4, 32'h0);
    wr(4'd8, 32'd3); wr(4'd9, 32'd3); wr(4'd10, 32'd3); wr(4'd11, 32'd1000);
    wr(4'd6, 32'h4 | (3 << 4) | (2 << 6) | (1 << 8));
    chk("R6 direct load", {28'd0, ext_match}, 32'h4);
    restart_run(0);
    edges(3);
    chk("R6 actions applied", {28'd0, ext_match}, 32'h3);

    // R2/R12: wrap
    wr(4'd0, 32'h0);
    wr(4'd1, 32'hFFFF_FFFE);
    rd(4'd1, v); chk("R12 count load", v, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    edges(1);
    rd(4'd1, v); chk("R2 top value", v, 32'hFFFF_FFFF);
    edges(1);
    rd(4'd1, v); chk("R2 wrap", v, 0);

    // R7: capture
    wr(4'd0, 32'h0);
    wr(4'd7, 32'hFF);
    wr(4'd1, 32'd1234);
    wr(4'd5, (1 << 6) | (1 << 8));
    cap_in[2] = 1'b1; edges(4);
    rd(4'd14, v); chk("R7 rising capture", v, 1234);
    rd(4'd7, v); chk("R7 capture flag", v, 32'h40);
    wr(4'd1, 32'd999);
    cap_in[2] = 1'b0; edges(4);
    rd(4'd14, v); chk("R7 disabled edge ignored", v, 1234);
    wr(4'd5, (1 << 6) | (1 << 8) | (1 << 1));
    wr(4'd7, 32'hFF);
    cap_in[0] = 1'b1; edges(4);
    rd(4'd12, v); chk("R7 rise not enabled", v, 0);
    cap_in[0] = 1'b0; edges(4);
    rd(4'd12, v); chk("R7 falling capture", v, 999);
    rd(4'd7, v); chk("R7 no flag without irq", v, 0);

    // R8: counter mode on input 1
    wr(4'd5, 32'h0);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1 | (3 << 2) | (1 << 4));
    toggle_cap(1, 5);
    rd(4'd1, v); chk("R8 both edges", v, 5);
    rd(4'd3, v); chk("R8 prescale idle", v, 0);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1 | (1 << 2) | (1 << 4));
    toggle_cap(1, 6);
    rd(4'd1, v); chk("R8 rising edges", v, 3);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1 | (2 << 2) | (1 << 4));
    toggle_cap(1, 4);
    rd(4'd1, v); chk("R8 falling edges", v, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule